// File: doc/BRIEF.md
# Flash Command Decoder and Status Register

This block sits between a host write bus and the program/erase engine of a flash-style memory. It watches every bus write, recognises two-write command sequences for a single-word program and for a whole-device erase, and checks each request against a programming-voltage-low flag, per-block lock bits and a write-protect input before handing it on. Accepted operations go to an abstract write engine, which is modelled as a busy countdown of fixed length. A program verify failure can be injected through a stuck-bit mask.

Results appear in an 8-bit status byte. Bit 7 shows whether the engine is ready. The error bits are sticky and are cleared only by an explicit command. A mode flag chooses what a read returns. After a program or erase setup, or an explicit status-read command, reads return the status byte. A read-array command switches reads back to the array data input.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return `arr_rdata` (array mode, `status_mode`=0), and the status byte is 8'h80 (ready, no error bits).
- R2: A setup write of 8'h40 or 8'h10, followed by any second write, starts a program. In the cycle after the second write, `pgm_go` is high for exactly one cycle, and `pgm_addr`/`pgm_data` carry that write's address and data.
- R3: Write 8'h30 followed by 8'hD0 to start an erase. `erase_go` then pulses for one cycle. `erase_mask` is all ones when `wp_n` is 1, and `~blk_lock` when `wp_n` is 0.
- R4: After an 8'h30 setup, a second write other than 8'hD0 starts no erase and sets status bits 5 and 4.
- R5: An erase confirmed while `vpp_low` is 1 starts no erase and sets status bits 5 and 3.
- R6: A program second write while `vpp_low` is 1 starts no program and sets status bits 5 and 4.
- R7: A program whose block is locked, while `wp_n` is 0, starts no program and sets status bits 4 and 1. The block index is the top log2(NBLK) address bits. The program proceeds if `wp_n` is 1 or the block is unlocked.
- R8: Status bit 7 is 0 for BUSY_CYC cycles, counted from the clock edge that accepts an operation, and is 1 otherwise. Bits 6, 2 and 0 always read 0.
- R9: A program fails verify only when `fault_mask` marks a bit whose written data is 0. Such a failure sets status bit 4 when the busy period ends. Marked bits written as 1 cause no failure.
- R10: Error bits 5, 4, 3 and 1 stay set through later operations until a write of 8'h50 clears them. 8'h50 does not change the read mode.
- R11: A program setup, an erase setup or 8'h70 selects status reads. 8'hFF selects array reads. Any other single write leaves the mode unchanged.
- R12: While busy, the setup codes 8'h40, 8'h10 and 8'h30 are ignored, so a following 8'hD0 or data write starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 8 | Bus write data / command code |
| vpp_low | input | 1 | Programming voltage below lockout |
| wp_n | input | 1 | Write protect, active low |
| blk_lock | input | NBLK | Lock bit per block |
| fault_mask | input | 8 | Injected stuck-at-1 cells for verify |
| arr_rdata | input | 8 | Array data returned in array read mode |
| rd_data | output | 8 | Read data: status byte or array data |
| status_mode | output | 1 | 1 when reads return the status byte |
| pgm_go | output | 1 | One-cycle program launch pulse |
| pgm_addr | output | ADDR_W | Program target address |
| pgm_data | output | 8 | Program data |
| erase_go | output | 1 | One-cycle erase launch pulse |
| erase_mask | output | NBLK | Blocks to be erased |

## Verification
The program sequence is driven with both setup codes, with addresses in locked and unlocked blocks, and with write-protect at both levels. This separates the lock check from the voltage check, because each rejection sets a distinct pair of status bits. Erase is tried with the correct confirm code, a wrong confirm code and a low programming voltage, and also with write-protect low so that the erase mask is shown to follow the lock bits. Fault masks that overlap the data on 1 bits and on 0 bits show that only failures where a 0 did not program are reported. Setup codes written during a busy period show that the sequence machine ignores them.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam logic [7:0] OP_PROG     = 8'h40;
    localparam logic [7:0] OP_PROG_ALT = 8'h10;
    localparam logic [7:0] OP_WIPE     = 8'h30;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_CLEAR    = 8'h50;
    localparam logic [7:0] OP_RD_STAT  = 8'h70;
    localparam logic [7:0] OP_RD_ARRAY = 8'hFF;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PROG = 2'd1,
        SEQ_WIPE = 2'd2
    } seq_e;

    // Error request, one field per sticky status bit.
    typedef struct packed {
        logic b5_erase;
        logic b4_prog;
        logic b3_vpp;
        logic b1_lock;
    } err_t;

endpackage

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
    import fcmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NBLK   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic              vpp_low,
    input  logic              wp_n,
    input  logic [NBLK-1:0]   blk_lock,
    output logic              launch,
    output logic              launch_prog,
    output err_t              err_set,
    output logic              clr_req,
    output logic              status_mode,
    output logic              pgm_go,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [7:0]        pgm_data,
    output logic              erase_go,
    output logic [NBLK-1:0]   erase_mask
);

    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1;

    typedef struct packed {
        seq_e              seq;
        logic              smode;
        logic              pgo;
        logic [ADDR_W-1:0] paddr;
        logic [7:0]        pdata;
        logic              ego;
        logic [NBLK-1:0]   emask;
    } dec_t;

    dec_t q, d;
    logic [BLK_W-1:0] blk_idx;
    logic             blk_locked;

    always_comb begin
        blk_idx    = wr_addr[ADDR_W-1 -: BLK_W];
        blk_locked = blk_lock[blk_idx];
    end

    always_comb begin
        d           = q;
        d.pgo       = 1'b0;
        d.ego       = 1'b0;
        launch      = 1'b0;
        launch_prog = 1'b0;
        err_set     = '0;
        clr_req     = 1'b0;
        if (wr_en) begin
            unique case (q.seq)
                SEQ_IDLE: begin
                    unique case (wr_data)
                        OP_PROG, OP_PROG_ALT: begin
                            if (!busy) begin
                                d.seq   = SEQ_PROG;
                                d.smode = 1'b1;
                            end
                        end
                        OP_WIPE: begin
                            if (!busy) begin
                                d.seq   = SEQ_WIPE;
                                d.smode = 1'b1;
                            end
                        end
                        OP_CLEAR:    clr_req = 1'b1;
                        OP_RD_STAT:  d.smode = 1'b1;
                        OP_RD_ARRAY: d.smode = 1'b0;
                        default: ;
                    endcase
                end
                SEQ_PROG: begin
                    d.seq = SEQ_IDLE;
                    if (vpp_low) begin
                        err_set.b5_erase = 1'b1;
                        err_set.b4_prog  = 1'b1;
                    end else if (blk_locked && !wp_n) begin
                        err_set.b4_prog  = 1'b1;
                        err_set.b1_lock  = 1'b1;
                    end else begin
                        launch      = 1'b1;
                        launch_prog = 1'b1;
                        d.pgo       = 1'b1;
                        d.paddr     = wr_addr;
                        d.pdata     = wr_data;
                    end
                end
                SEQ_WIPE: begin
                    d.seq = SEQ_IDLE;
                    if (wr_data != OP_CONFIRM) begin
                        err_set.b5_erase = 1'b1;
                        err_set.b4_prog  = 1'b1;
                    end else if (vpp_low) begin
                        err_set.b5_erase = 1'b1;
                        err_set.b3_vpp   = 1'b1;
                    end else begin
                        launch  = 1'b1;
                        d.ego   = 1'b1;
                        d.emask = wp_n ? {NBLK{1'b1}} : ~blk_lock;
                    end
                end
                default: d.seq = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{seq: SEQ_IDLE, smode: 1'b0, pgo: 1'b0, paddr: '0,
                   pdata: '0, ego: 1'b0, emask: '0};
        end else begin
            q <= d;
        end
    end

    assign status_mode = q.smode;
    assign pgm_go      = q.pgo;
    assign pgm_addr    = q.paddr;
    assign pgm_data    = q.pdata;
    assign erase_go    = q.ego;
    assign erase_mask  = q.emask;

    // R12: the engine never receives a launch while it is busy
    a_r12_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !launch);

    // R2: program launch is a single-cycle pulse
    a_r2_pgm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_go |=> !pgm_go);

    // R3: erase launch is a single-cycle pulse
    a_r3_erase_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> !erase_go);

endmodule

// File: rtl/fcmd_engine.sv
module fcmd_engine #(
    parameter int BUSY_CYC = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       launch_prog,
    input  logic [7:0] prog_data,
    input  logic [7:0] fault_mask,
    output logic       busy,
    output logic       fail_set
);

    localparam int CNT_W = $clog2(BUSY_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fail;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d = q;
        if (launch) begin
            d.cnt  = CNT_LOAD;
            // a marked cell only fails when it must go from 1 to 0
            d.fail = launch_prog && (|(fault_mask & ~prog_data));
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) d.fail = 1'b0;
        end
        busy     = (q.cnt != '0);
        fail_set = (q.cnt == CNT_W'(1)) && q.fail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: an accepted operation makes the engine busy on the next cycle
    a_r8_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);

    // R8: the countdown never exceeds its load value
    a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_LOAD);

endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
    import fcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  err_t       err_set,
    input  logic       fail_set,
    input  logic       clr_req,
    input  logic       busy,
    output logic [7:0] status
);

    err_t q, d;

    always_comb begin
        d = q;
        if (clr_req) d = '0;
        d.b5_erase = d.b5_erase | err_set.b5_erase;
        d.b4_prog  = d.b4_prog  | err_set.b4_prog | fail_set;
        d.b3_vpp   = d.b3_vpp   | err_set.b3_vpp;
        d.b1_lock  = d.b1_lock  | err_set.b1_lock;
        status = {~busy, 1'b0, q.b5_erase, q.b4_prog, q.b3_vpp, 1'b0, q.b1_lock, 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R10: error bits stay set until a clear command
    a_r10_sticky_b4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.b4_prog && !clr_req) |=> q.b4_prog);
    a_r10_sticky_b5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.b5_erase && !clr_req) |=> q.b5_erase);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcmd_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NBLK     = 4,
    parameter int BUSY_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              vpp_low,
    input  logic              wp_n,
    input  logic [NBLK-1:0]   blk_lock,
    input  logic [7:0]        fault_mask,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        rd_data,
    output logic              status_mode,
    output logic              pgm_go,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [7:0]        pgm_data,
    output logic              erase_go,
    output logic [NBLK-1:0]   erase_mask
);

    logic       launch, launch_prog, clr_req, busy, fail_set;
    err_t       err_set;
    logic [7:0] status;

    fcmd_decoder #(.ADDR_W(ADDR_W), .NBLK(NBLK)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .vpp_low(vpp_low), .wp_n(wp_n), .blk_lock(blk_lock),
        .launch(launch), .launch_prog(launch_prog), .err_set(err_set),
        .clr_req(clr_req), .status_mode(status_mode),
        .pgm_go(pgm_go), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .erase_go(erase_go), .erase_mask(erase_mask)
    );

    fcmd_engine #(.BUSY_CYC(BUSY_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_prog(launch_prog),
        .prog_data(wr_data), .fault_mask(fault_mask),
        .busy(busy), .fail_set(fail_set)
    );

    fcmd_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .err_set(err_set), .fail_set(fail_set), .clr_req(clr_req),
        .busy(busy), .status(status)
    );

    assign rd_data = status_mode ? status : arr_rdata;

    // R8: reserved status bits are always zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6] == 1'b0) && (status[2] == 1'b0) && (status[0] == 1'b0));

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;

    localparam int ADDR_W = 12;
    localparam int NBLK   = 4;
    localparam int BUSY   = 6;
    localparam logic [7:0] ARR = 8'h5A;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              vpp_low = 1'b0;
    logic              wp_n = 1'b1;
    logic [NBLK-1:0]   blk_lock = '0;
    logic [7:0]        fault_mask = '0;
    logic [7:0]        arr_rdata = ARR;
    logic [7:0]        rd_data;
    logic              status_mode, pgm_go, erase_go;
    logic [ADDR_W-1:0] pgm_addr;
    logic [7:0]        pgm_data;
    logic [NBLK-1:0]   erase_mask;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .NBLK(NBLK), .BUSY_CYC(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vpp_low(vpp_low), .wp_n(wp_n),
        .blk_lock(blk_lock), .fault_mask(fault_mask), .arr_rdata(arr_rdata),
        .rd_data(rd_data), .status_mode(status_mode), .pgm_go(pgm_go),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data), .erase_go(erase_go),
        .erase_mask(erase_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus write; returns at the falling edge after the capturing edge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // called right after the accepting write: checks the busy window length
    task automatic wait_busy(input string req);
        chk(req, 32'(rd_data[7]), 32'd0);
        repeat (BUSY - 1) @(negedge clk);
        chk(req, 32'(rd_data[7]), 32'd0);
        @(negedge clk);
        chk(req, 32'(rd_data[7]), 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 array mode", 32'(status_mode), 32'd0);
        chk("R1 array data", 32'(rd_data), 32'(ARR));
        wr('0, 8'h70);
        chk("R1 status after reset", 32'(rd_data), 32'h80);
    endtask

    task automatic t_program(input logic [7:0] setup);
        wr('0, 8'hFF);
        wr('0, setup);
        chk("R11 status after setup", 32'(status_mode), 32'd1);
        chk("R2 no go on setup", 32'(pgm_go), 32'd0);
        wr(12'h123, 8'hA5);
        chk("R2 pgm_go", 32'(pgm_go), 32'd1);
        chk("R2 pgm_addr", 32'(pgm_addr), 32'h123);
        chk("R2 pgm_data", 32'(pgm_data), 32'hA5);
        wait_busy("R8 program busy");
        chk("R2 single pulse", 32'(pgm_go), 32'd0);
        chk("R8 clean status", 32'(rd_data), 32'h80);
    endtask

    task automatic t_busy_ignore;
        wr(12'h010, 8'h40);
        wr(12'h010, 8'h00);
        wr('0, 8'h30);
        wr('0, 8'hD0);
        chk("R12 no erase while busy", 32'(erase_go), 32'd0);
        wr('0, 8'h40);
        wr(12'h020, 8'h33);
        chk("R12 no program while busy", 32'(pgm_go), 32'd0);
        repeat (BUSY) @(negedge clk);
        chk("R12 no error from ignored writes", 32'(rd_data), 32'h80);
    endtask

    task automatic t_verify;
        fault_mask = 8'h01;
        wr('0, 8'h40);
        wr(12'h004, 8'h01);
        wait_busy("R9 pass busy");
        chk("R9 marked bit written as 1 passes", 32'(rd_data), 32'h80);
        wr('0, 8'h40);
        wr(12'h004, 8'hF0);
        wait_busy("R9 fail busy");
        chk("R9 marked bit written as 0 fails", 32'(rd_data), 32'h90);
        fault_mask = 8'h00;
        wr('0, 8'h40);
        wr(12'h008, 8'h00);
        wait_busy("R10 busy");
        chk("R10 bit4 stays set", 32'(rd_data), 32'h90);
        wr('0, 8'h50);
        chk("R10 cleared", 32'(rd_data), 32'h80);
        chk("R10 mode kept", 32'(status_mode), 32'd1);
    endtask

    task automatic t_vpp_prog;
        vpp_low = 1'b1;
        wr('0, 8'h10);
        wr(12'h040, 8'h00);
        chk("R6 no program", 32'(pgm_go), 32'd0);
        chk("R6 bits 5,4 and ready", 32'(rd_data), 32'hB0);
        vpp_low = 1'b0;
        wr('0, 8'h50);
    endtask

    task automatic t_lock;
        blk_lock = 4'b0100;
        wp_n = 1'b0;
        wr('0, 8'h40);
        wr(12'h800, 8'h00);
        chk("R7 locked refused", 32'(pgm_go), 32'd0);
        chk("R7 bits 4,1", 32'(rd_data), 32'h92);
        wr('0, 8'h50);
        wr('0, 8'h40);
        wr(12'h400, 8'h00);
        chk("R7 unlocked block programs", 32'(pgm_go), 32'd1);
        wait_busy("R7 busy");
        wp_n = 1'b1;
        wr('0, 8'h40);
        wr(12'h800, 8'h00);
        chk("R7 wp_n high overrides lock", 32'(pgm_go), 32'd1);
        wait_busy("R7 busy2");
        chk("R7 no error", 32'(rd_data), 32'h80);
    endtask

    task automatic t_erase;
        wp_n = 1'b1;
        blk_lock = 4'b0100;
        wr('0, 8'h30);
        wr('0, 8'hD0);
        chk("R3 erase_go", 32'(erase_go), 32'd1);
        chk("R3 mask all", 32'(erase_mask), 32'hF);
        wait_busy("R8 erase busy");
        wp_n = 1'b0;
        wr('0, 8'h30);
        wr('0, 8'hD0);
        chk("R3 erase_go wp low", 32'(erase_go), 32'd1);
        chk("R3 mask unlocked only", 32'(erase_mask), 32'hB);
        wait_busy("R3 busy");
        wp_n = 1'b1;
        blk_lock = '0;
    endtask

    task automatic t_bad_confirm;
        wr('0, 8'h30);
        wr('0, 8'h40);
        chk("R4 no erase", 32'(erase_go), 32'd0);
        chk("R4 bits 5,4", 32'(rd_data), 32'hB0);
        wr('0, 8'h50);
        vpp_low = 1'b1;
        wr('0, 8'h30);
        wr('0, 8'hD0);
        chk("R5 no erase", 32'(erase_go), 32'd0);
        chk("R5 bits 5,3", 32'(rd_data), 32'hA8);
        vpp_low = 1'b0;
        wr('0, 8'h50);
        chk("R10 clear all", 32'(rd_data), 32'h80);
    endtask

    task automatic t_mode;
        wr('0, 8'hFF);
        chk("R11 array after FF", 32'(rd_data), 32'(ARR));
        wr('0, 8'h00);
        chk("R11 unknown keeps mode", 32'(status_mode), 32'd0);
        wr('0, 8'h50);
        chk("R11 clear keeps array mode", 32'(rd_data), 32'(ARR));
        wr('0, 8'h70);
        chk("R11 status after 70", 32'(rd_data), 32'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program(8'h40);
        t_program(8'h10);
        t_busy_ignore();
        t_verify();
        t_vpp_prog();
        t_lock();
        t_erase();
        t_bad_confirm();
        t_mode();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule